// File: doc/BRIEF.md
# Serial Shift Register with Output Latch

This block is the data path of a small synchronous serial port. An 8-bit shift register samples a serial input pin and shifts toward its most significant bit. The serial output pin is taken from that MSB through a hold stage, so the input is sampled and the output changes on opposite serial clock edges. The serial clock comes either from an external pin, which is synchronized into the system clock domain, or from a software clock that the CPU advances one edge per strobe.

The CPU can load the shift register in parallel and read it back at any time. When a byte has been moved, the block copies the shifted byte into a read-only buffer register and raises a sticky completion flag. The CPU can then collect the result later and does not have to race the next transfer. The output pad is driven only while the CPU sets the direction enable.

Top module: `ssr_serial_port`

## Requirements
- R1: After reset the shift register, the buffer register, the completion flag and the serial output all read 0. The output enable follows the direction input, which is 0 in reset.
- R2: A CPU write loads all 8 bits in parallel, and the new value is readable on the next cycle. A write overrides a shift that falls in the same cycle.
- R3: On each first (rising) serial clock edge, the synchronized data input is captured into a one-bit holding stage. On each second (falling) edge, the register shifts left and the held bit enters bit 0.
- R4: A 4-bit counter counts every serial clock edge. On the 16th edge the shifted byte is copied into the buffer register. The buffer changes at no other time.
- R5: The completion flag is set on the 16th edge and stays set until the CPU pulses the clear input. If both happen in the same cycle, the set wins.
- R6: With the external clock selected, the output pin follows bit 7 while the synchronized clock is high. While it is low, the pin holds its last value, even across CPU writes.
- R7: With the software clock selected, the output pin always equals bit 7 of the register, and a CPU write shows on it in the cycle after the write.
- R8: The output enable equals the direction input, and the pin is meant to float when that enable is 0.
- R9: The external clock and data pins pass through a two-flop synchronizer. A pin edge affects the register on the third system clock edge after the pin changes.
- R10: Edges on the external clock pin have no effect while the software clock is selected. Software clock strobes have no effect while the external clock is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_sel_ext | input | 1 | 1 selects the external serial clock, 0 the software clock |
| sw_tick | input | 1 | One-cycle strobe that advances the software clock by one edge |
| ser_clk_in | input | 1 | External serial clock pin |
| ser_din | input | 1 | Serial data input pin |
| dr_wr_en | input | 1 | CPU write strobe for the shift register |
| dr_wdata | input | 8 | CPU write data |
| dr_rdata | output | 8 | Current shift register contents |
| buf_rdata | output | 8 | Buffer register, loaded when a transfer completes |
| done_flag | output | 1 | Sticky transfer-complete flag |
| done_clr | input | 1 | Write-one clear of the completion flag |
| dout_dir | input | 1 | Direction enable for the serial output pad |
| ser_dout | output | 1 | Serial data output value |
| ser_dout_oe | output | 1 | Output enable for the serial output pad |

## Verification
The bench targets the hold phase of the output stage. A CPU write made while the external clock is low must not reach the pin until the clock rises; a design with the stage always open would show the new MSB at once. It also targets the case where a write and a shift land in the same cycle: if the shift won, the register would read a shifted value instead of the written one. It checks the exact synchronizer latency: a design with one stage too few or too many would shift a cycle early or late. It checks that the buffer loads only on the 16th edge: an off-by-one counter would load half a bit early or late. It also checks mode isolation: activity on the clock source that is not selected must leave the register untouched.

// File: rtl/ssr_pkg.sv
package ssr_pkg;

  typedef struct packed {
    logic rise;
    logic fall;
  } ssr_edge_t;

endpackage

// File: rtl/ssr_clk_front.sv
module ssr_clk_front
  import ssr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sel_ext_i,
  input  logic      sclk_pin_i,
  input  logic      din_pin_i,
  input  logic      sw_tick_i,
  output ssr_edge_t edge_o,
  output logic      sclk_lvl_o,
  output logic      din_sync_o
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES:0]   sclk_q, sclk_d;
  logic [SYNC_STAGES-1:0] din_q, din_d;
  logic                   int_lvl_q, int_lvl_d;
  logic                   ext_rise, ext_fall, int_tick;

  always_comb begin
    sclk_d    = {sclk_q[SYNC_STAGES-1:0], sclk_pin_i};
    din_d     = {din_q[SYNC_STAGES-2:0], din_pin_i};
    int_tick  = sw_tick_i & ~sel_ext_i;
    int_lvl_d = int_lvl_q ^ int_tick;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q    <= '0;
      din_q     <= '0;
      int_lvl_q <= 1'b0;
    end else begin
      sclk_q    <= sclk_d;
      din_q     <= din_d;
      int_lvl_q <= int_lvl_d;
    end
  end

  assign ext_rise = sclk_q[LAST] & ~sclk_q[SYNC_STAGES];
  assign ext_fall = ~sclk_q[LAST] & sclk_q[SYNC_STAGES];

  always_comb begin
    if (sel_ext_i) begin
      edge_o.rise = ext_rise;
      edge_o.fall = ext_fall;
    end else begin
      edge_o.rise = int_tick & ~int_lvl_q;
      edge_o.fall = int_tick & int_lvl_q;
    end
  end

  assign sclk_lvl_o = sclk_q[LAST];
  assign din_sync_o = din_q[LAST];

endmodule

// File: rtl/ssr_shift_core.sv
module ssr_shift_core
  import ssr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ssr_edge_t         edge_i,
  input  logic              din_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              clr_i,
  output logic [DATA_W-1:0] sr_o,
  output logic [DATA_W-1:0] buf_o,
  output logic              done_o
);

  localparam int EDGES = 2 * DATA_W;
  localparam int CNT_W = $clog2(EDGES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(EDGES - 1);

  logic              samp_q, samp_d;
  logic [DATA_W-1:0] sr_q, sr_d, buf_q, buf_d, shifted;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              done_q, done_d;
  logic              any_edge, wrap;

  always_comb begin
    any_edge = edge_i.rise | edge_i.fall;
    wrap     = any_edge & (cnt_q == CNT_LAST);
    shifted  = {sr_q[DATA_W-2:0], samp_q};
    samp_d   = samp_q;
    sr_d     = sr_q;
    cnt_d    = cnt_q;
    buf_d    = buf_q;
    done_d   = done_q;
    if (edge_i.rise) samp_d = din_i;
    if (edge_i.fall) sr_d = shifted;
    if (wr_en_i) sr_d = wdata_i;
    if (any_edge) cnt_d = wrap ? '0 : cnt_q + 1'b1;
    if (clr_i) done_d = 1'b0;
    if (wrap) begin
      done_d = 1'b1;
      buf_d  = edge_i.fall ? shifted : sr_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q <= 1'b0;
      sr_q   <= '0;
      cnt_q  <= '0;
      buf_q  <= '0;
      done_q <= 1'b0;
    end else begin
      samp_q <= samp_d;
      sr_q   <= sr_d;
      cnt_q  <= cnt_d;
      buf_q  <= buf_d;
      done_q <= done_d;
    end
  end

  assign sr_o   = sr_q;
  assign buf_o  = buf_q;
  assign done_o = done_q;

endmodule

// File: rtl/ssr_out_latch.sv
module ssr_out_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic open_i,
  input  logic msb_i,
  input  logic dir_i,
  output logic dout_o,
  output logic oe_o
);

  logic hold_q, hold_d;

  always_comb begin
    dout_o = open_i ? msb_i : hold_q;
    hold_d = dout_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= hold_d;
  end

  assign oe_o = dir_i;

endmodule

// File: rtl/ssr_serial_port.sv
module ssr_serial_port
  import ssr_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_sel_ext,
  input  logic              sw_tick,
  input  logic              ser_clk_in,
  input  logic              ser_din,
  input  logic              dr_wr_en,
  input  logic [DATA_W-1:0] dr_wdata,
  output logic [DATA_W-1:0] dr_rdata,
  output logic [DATA_W-1:0] buf_rdata,
  output logic              done_flag,
  input  logic              done_clr,
  input  logic              dout_dir,
  output logic              ser_dout,
  output logic              ser_dout_oe
);

  ssr_edge_t edge_w;
  logic      sclk_lvl;
  logic      din_sync;
  logic      latch_open;

  ssr_clk_front #(.SYNC_STAGES(SYNC_STAGES)) front_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_ext_i  (clk_sel_ext),
    .sclk_pin_i (ser_clk_in),
    .din_pin_i  (ser_din),
    .sw_tick_i  (sw_tick),
    .edge_o     (edge_w),
    .sclk_lvl_o (sclk_lvl),
    .din_sync_o (din_sync)
  );

  ssr_shift_core #(.DATA_W(DATA_W)) core_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .edge_i  (edge_w),
    .din_i   (din_sync),
    .wr_en_i (dr_wr_en),
    .wdata_i (dr_wdata),
    .clr_i   (done_clr),
    .sr_o    (dr_rdata),
    .buf_o   (buf_rdata),
    .done_o  (done_flag)
  );

  assign latch_open = ~clk_sel_ext | sclk_lvl;

  ssr_out_latch out_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .open_i (latch_open),
    .msb_i  (dr_rdata[DATA_W-1]),
    .dir_i  (dout_dir),
    .dout_o (ser_dout),
    .oe_o   (ser_dout_oe)
  );

endmodule

// File: rtl/ssr_serial_port_chk.sv
module ssr_serial_port_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clk_sel_ext,
  input logic              sw_tick,
  input logic              dr_wr_en,
  input logic [DATA_W-1:0] dr_wdata,
  input logic [DATA_W-1:0] dr_rdata,
  input logic [DATA_W-1:0] buf_rdata,
  input logic              done_flag,
  input logic              done_clr,
  input logic              ser_dout,
  input logic              sclk_lvl
);

  assert_write_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dr_wr_en |=> dr_rdata == $past(dr_wdata));

  assert_buf_only_on_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(buf_rdata) |-> done_flag);

  assert_done_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_flag && !done_clr) |=> done_flag);

  assert_hold_when_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel_ext && $past(clk_sel_ext) && !sclk_lvl) |-> $stable(ser_dout));

  assert_sw_transparent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_sel_ext |-> ser_dout == dr_rdata[DATA_W-1]);

  assert_sw_idle_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_sel_ext && !sw_tick && !dr_wr_en) |=> $stable(dr_rdata));

endmodule

bind ssr_serial_port ssr_serial_port_chk #(.DATA_W(DATA_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .clk_sel_ext (clk_sel_ext),
  .sw_tick     (sw_tick),
  .dr_wr_en    (dr_wr_en),
  .dr_wdata    (dr_wdata),
  .dr_rdata    (dr_rdata),
  .buf_rdata   (buf_rdata),
  .done_flag   (done_flag),
  .done_clr    (done_clr),
  .ser_dout    (ser_dout),
  .sclk_lvl    (sclk_lvl)
);

// File: tb/ssr_serial_port_tb.sv
`timescale 1ns/1ps
module ssr_serial_port_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       clk_sel_ext;
  logic       sw_tick;
  logic       ser_clk_in;
  logic       ser_din;
  logic       dr_wr_en;
  logic [7:0] dr_wdata;
  logic [7:0] dr_rdata;
  logic [7:0] buf_rdata;
  logic       done_flag;
  logic       done_clr;
  logic       dout_dir;
  logic       ser_dout;
  logic       ser_dout_oe;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  ssr_serial_port dut_i (.*);

  // Behavioural reference model
  logic       sq[$];
  logic       dq[$];
  logic [7:0] m_sr, m_buf;
  logic       m_samp, m_done, m_hold, m_ilvl;
  int         m_cnt;

  always @(posedge clk) begin
    logic s2, s3, d2, rise, fall, open, dpre, wrap;
    if (!rst_n) begin
      sq = '{1'b0, 1'b0, 1'b0};
      dq = '{1'b0, 1'b0};
      m_sr = 8'h00; m_buf = 8'h00; m_samp = 1'b0; m_done = 1'b0;
      m_hold = 1'b0; m_ilvl = 1'b0; m_cnt = 0;
    end else begin
      s2 = sq[1]; s3 = sq[2]; d2 = dq[1];
      if (clk_sel_ext) begin
        rise = s2 && !s3;
        fall = !s2 && s3;
      end else begin
        rise = sw_tick && !m_ilvl;
        fall = sw_tick && m_ilvl;
        if (sw_tick) m_ilvl = !m_ilvl;
      end
      open = !clk_sel_ext || s2;
      dpre = open ? m_sr[7] : m_hold;
      m_hold = dpre;
      wrap = (rise || fall) && (m_cnt == 15);
      if (done_clr) m_done = 1'b0;
      if (wrap) begin
        m_done = 1'b1;
        m_buf  = fall ? {m_sr[6:0], m_samp} : m_sr;
      end
      if (rise || fall) m_cnt = (m_cnt + 1) % 16;
      if (fall) m_sr = {m_sr[6:0], m_samp};
      if (dr_wr_en) m_sr = dr_wdata;
      if (rise) m_samp = d2;
      sq.push_front(ser_clk_in); void'(sq.pop_back());
      dq.push_front(ser_din);    void'(dq.pop_back());
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n === 1'b1 && sq.size() == 3) begin
      chk("R3 register", dr_rdata, m_sr);
      chk("R4 buffer", buf_rdata, m_buf);
      chk("R5 flag", {7'd0, done_flag}, {7'd0, m_done});
      chk("R8 oe", {7'd0, ser_dout_oe}, {7'd0, dout_dir});
      chk("R6 R7 dout", {7'd0, ser_dout},
          {7'd0, ((!clk_sel_ext || sq[1]) ? m_sr[7] : m_hold)});
    end
  end

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic cpu_write(input logic [7:0] v);
    dr_wr_en = 1'b1; dr_wdata = v;
    step();
    dr_wr_en = 1'b0;
  endtask

  task automatic tick();
    sw_tick = 1'b1;
    step();
    sw_tick = 1'b0;
    step();
  endtask

  task automatic send_int(input logic [7:0] v, input int nbits);
    for (int i = nbits - 1; i >= 0; i--) begin
      ser_din = v[i];
      step(2);
      tick();
      tick();
    end
  endtask

  task automatic send_ext(input logic [7:0] v, input int nbits);
    for (int i = nbits - 1; i >= 0; i--) begin
      ser_din = v[i];
      step(3);
      ser_clk_in = 1'b1;
      step(4);
      ser_clk_in = 1'b0;
      step(4);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #1000000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; clk_sel_ext = 1'b0; sw_tick = 1'b0; ser_clk_in = 1'b0;
    ser_din = 1'b0; dr_wr_en = 1'b0; dr_wdata = 8'h00; done_clr = 1'b0;
    dout_dir = 1'b0;
    step(3);
    rst_n = 1'b1;
    step();
    // R1 reset state
    chk("R1 reg", dr_rdata, 8'h00);
    chk("R1 buf", buf_rdata, 8'h00);
    chk("R1 flag", {7'd0, done_flag}, 8'h00);
    chk("R1 dout", {7'd0, ser_dout}, 8'h00);
    chk("R1 oe", {7'd0, ser_dout_oe}, 8'h00);

    dout_dir = 1'b1;
    cpu_write(8'h3C);
    chk("R2 load", dr_rdata, 8'h3C);
    chk("R7 msb0", {7'd0, ser_dout}, 8'h00);
    cpu_write(8'hC3);
    chk("R7 msb1", {7'd0, ser_dout}, 8'h01);
    chk("R8 oe on", {7'd0, ser_dout_oe}, 8'h01);

    send_int(8'hA5, 8);
    chk("R3 shifted", dr_rdata, 8'hA5);
    chk("R4 buf", buf_rdata, 8'hA5);
    chk("R5 set", {7'd0, done_flag}, 8'h01);

    done_clr = 1'b1; step(); done_clr = 1'b0;
    chk("R5 clear", {7'd0, done_flag}, 8'h00);

    // R10: external pin toggling while the software clock is selected
    for (int k = 0; k < 4; k++) begin
      ser_clk_in = ~ser_clk_in;
      step(4);
    end
    chk("R10 ext ignored", dr_rdata, 8'hA5);

    // R2 write wins over a shift in the same cycle
    ser_din = 1'b1; step(2);
    tick();
    sw_tick = 1'b1; dr_wr_en = 1'b1; dr_wdata = 8'h77;
    step();
    sw_tick = 1'b0; dr_wr_en = 1'b0;
    chk("R2 priority", dr_rdata, 8'h77);
    step();
    send_int(8'h00, 7);
    chk("R4 buf2", buf_rdata, 8'h80);
    chk("R5 set2", {7'd0, done_flag}, 8'h01);
    done_clr = 1'b1; step(); done_clr = 1'b0;

    // External clock mode
    clk_sel_ext = 1'b1;
    step(3);
    sw_tick = 1'b1; step(); sw_tick = 1'b0; step();
    chk("R10 tick ignored", dr_rdata, 8'h80);
    cpu_write(8'h00);
    chk("R6 hold low", {7'd0, ser_dout}, 8'h01);
    step(2);
    chk("R6 hold still", {7'd0, ser_dout}, 8'h01);
    cpu_write(8'h01);

    // R9 synchronizer latency on one bit
    ser_din = 1'b0; step(3);
    ser_clk_in = 1'b1; step(4);
    chk("R6 open high", {7'd0, ser_dout}, 8'h00);
    ser_clk_in = 1'b0;
    step(2);
    chk("R9 not yet", dr_rdata, 8'h01);
    step();
    chk("R9 shifted", dr_rdata, 8'h02);
    step(2);
    send_ext(8'h55, 7);
    chk("R3 ext byte", dr_rdata, 8'h55);
    chk("R4 ext buf", buf_rdata, 8'h55);
    chk("R5 ext set", {7'd0, done_flag}, 8'h01);

    dout_dir = 1'b0; step();
    chk("R8 oe off", {7'd0, ser_dout_oe}, 8'h00);
    step(2);
    finish_run();
  end

endmodule